// File: doc/BRIEF.md
# MDIO Management Slave Port

This block is the PHY-side end of a two-wire serial management link. Every rising edge of the management clock samples the data line. A control sequencer waits for a preamble of ones and a start pattern, then takes in a read or write opcode, a 5-bit PHY address and a 5-bit register address. After that it either sends out 16 bits of register data or collects 16 bits to write. The bidirectional data line is modelled as a data output plus an output enable. The open-drain pad and its pull-up are not part of the block.

The block does not hold the registers. It presents a register address to an external register file and gets back the read value and a flag saying whether a register exists at that address. A write leaves the block as a one-cycle strobe with its data. The PHY address the block answers to is a parameter with default 1. The block also answers frames sent to address zero.

Top module: `mdio_slave`

## Requirements
- R1: While reset is asserted, the output enable and the write strobe are both low.
- R2: A single one bit before the start pattern is enough preamble. A longer run of ones, such as 32, is also accepted.
- R3: Fields arrive most significant bit first, in this order: start `01`, opcode (`10` = read, `01` = write), a 5-bit PHY address, then a 5-bit register address. The captured register address appears on `reg_addr` and holds until the next frame's address field completes.
- R4: On a read addressed to this PHY, the line stays undriven during the first turnaround bit period. During the second turnaround bit period the block drives 0.
- R5: On that read, the block drives the 16 data bits MSB first, one per clock period. It releases the line in the period right after the last data bit.
- R6: On a write addressed to this PHY and to a present register, `reg_wr` pulses for exactly one cycle, on the clock after the edge that samples the sixteenth data bit, carrying all 16 bits on `reg_wdata`. No strobe occurs before that point.
- R7: The block responds to frames whose PHY address equals the parameter `PHY_ADDR` (default 1), and also to PHY address 0, for both reads and writes.
- R8: For a frame whose PHY address matches neither, the block never drives the line, so a read returns all ones through the pull-up, and a write has no effect.
- R9: A read of a register flagged absent drives 16 ones. A write to an absent register produces no strobe.
- R10: A start pattern other than `01`, or an opcode of `00` or `11`, ends the frame. There is no register access and no drive, and the block goes back to waiting for a preamble one, so a following valid frame is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; everything is registered on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_i | input | 1 | Sampled level of the shared data line |
| mdio_o | output | 1 | Value to drive on the data line |
| mdio_oe | output | 1 | High when the block drives the data line |
| reg_addr | output | 5 | Register address of the current frame |
| reg_rdata | input | 16 | Register file read data for `reg_addr` |
| reg_present | input | 1 | High when a register exists at `reg_addr` |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 16 | Data that goes with `reg_wr` |

## Verification
The hardest case to reach from the ports is a frame that dies in the middle, with an illegal start or opcode, while the following line bits could look like a new preamble and start. The stimulus sends the bad pattern and then a run of zeros, so the sequencer must end up back in preamble hunting. It then checks that the next legal frame is decoded correctly. A second hard case is the exact strobe cycle of a write. The bench samples the strobe both in the period before the sixteenth data bit and in the period after it.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;

    localparam int MDIO_AW = 5;
    localparam int MDIO_DW = 16;
    localparam int CNT_W   = $clog2(MDIO_DW + 1);

    typedef enum logic [2:0] {
        S_HUNT,
        S_PRE,
        S_ST,
        S_OP,
        S_ADDR,
        S_TA,
        S_WDATA,
        S_RDATA
    } mdio_st_e;

    typedef struct packed {
        mdio_st_e             st;
        logic [CNT_W-1:0]     cnt;
        logic [MDIO_DW-1:0]   sh;
        logic                 is_rd;
        logic                 hit;
        logic [MDIO_AW-1:0]   raddr;
        logic                 wr;
        logic [MDIO_DW-1:0]   wdata;
        logic                 oe;
    } mdio_ctl_t;

endpackage

// File: rtl/mdio_slv_match.sv
module mdio_slv_match #(
    parameter int             AW       = 5,
    parameter logic [AW-1:0]  PHY_ADDR = 1,
    parameter bit             BCAST_EN = 1'b1
) (
    input  logic [2*AW-1:0] field,
    output logic            hit,
    output logic [AW-1:0]   regad
);

    logic [AW-1:0] phyad;
    logic          own;
    logic          bcast;

    assign phyad = field[2*AW-1:AW];
    assign regad = field[AW-1:0];
    assign own   = (phyad == PHY_ADDR);

    generate
        if (BCAST_EN) begin : g_bcast
            assign bcast = (phyad == '0);
        end else begin : g_nobcast
            assign bcast = 1'b0;
        end
    endgenerate

    assign hit = own | bcast;

endmodule

// File: rtl/mdio_slv_txsr.sv
module mdio_slv_txsr #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          shift,
    input  logic [DW-1:0] load_val,
    output logic          bit_o
);

    logic [DW-1:0] q_d, q_q;
    logic          o_d, o_q;

    always_comb begin
        q_d = q_q;
        o_d = o_q;
        if (load) begin
            q_d = load_val;
            o_d = 1'b0;
        end else if (shift) begin
            o_d = q_q[DW-1];
            q_d = {q_q[DW-2:0], 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '1;
            o_q <= 1'b1;
        end else begin
            q_q <= q_d;
            o_q <= o_d;
        end
    end

    assign bit_o = o_q;

endmodule

// File: rtl/mdio_slave.sv
module mdio_slave
    import mdio_slv_pkg::*;
#(
    parameter logic [MDIO_AW-1:0] PHY_ADDR = 5'd1
) (
    input  logic               mdc,
    input  logic               rst_n,
    input  logic               mdio_i,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic [MDIO_AW-1:0] reg_addr,
    input  logic [MDIO_DW-1:0] reg_rdata,
    input  logic               reg_present,
    output logic               reg_wr,
    output logic [MDIO_DW-1:0] reg_wdata
);

    localparam int                AW        = MDIO_AW;
    localparam int                DW        = MDIO_DW;
    localparam logic [CNT_W-1:0]  ADDR_LAST = CNT_W'(2 * AW - 1);
    localparam logic [CNT_W-1:0]  DATA_LAST = CNT_W'(DW - 1);
    localparam logic [CNT_W-1:0]  RD_END    = CNT_W'(DW);

    mdio_ctl_t ctl_d, ctl_q;

    logic [2*AW-1:0] addr_field;
    logic            addr_hit;
    logic [AW-1:0]   addr_reg;
    logic            tx_load;
    logic            tx_shift;
    logic [DW-1:0]   tx_val;
    logic            tx_bit;

    assign addr_field = {ctl_q.sh[2*AW-2:0], mdio_i};

    mdio_slv_match #(
        .AW       (AW),
        .PHY_ADDR (PHY_ADDR),
        .BCAST_EN (1'b1)
    ) u_match (
        .field (addr_field),
        .hit   (addr_hit),
        .regad (addr_reg)
    );

    assign tx_load  = (ctl_q.st == S_TA) && ctl_q.is_rd && ctl_q.hit;
    assign tx_shift = (ctl_q.st == S_RDATA) && ctl_q.hit;
    assign tx_val   = reg_present ? reg_rdata : '1;

    mdio_slv_txsr #(
        .DW (DW)
    ) u_txsr (
        .clk      (mdc),
        .rst_n    (rst_n),
        .load     (tx_load),
        .shift    (tx_shift),
        .load_val (tx_val),
        .bit_o    (tx_bit)
    );

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.wr = 1'b0;
        unique case (ctl_q.st)
            S_HUNT: begin
                if (mdio_i) ctl_d.st = S_PRE;
            end
            S_PRE: begin
                if (!mdio_i) ctl_d.st = S_ST;
            end
            S_ST: begin
                ctl_d.cnt = '0;
                ctl_d.st  = mdio_i ? S_OP : S_HUNT;
            end
            S_OP: begin
                ctl_d.sh = {ctl_q.sh[DW-2:0], mdio_i};
                if (ctl_q.cnt == '0) begin
                    ctl_d.cnt = CNT_W'(1);
                end else begin
                    ctl_d.cnt = '0;
                    unique case ({ctl_q.sh[0], mdio_i})
                        2'b10: begin
                            ctl_d.is_rd = 1'b1;
                            ctl_d.st    = S_ADDR;
                        end
                        2'b01: begin
                            ctl_d.is_rd = 1'b0;
                            ctl_d.st    = S_ADDR;
                        end
                        default: ctl_d.st = S_HUNT;
                    endcase
                end
            end
            S_ADDR: begin
                ctl_d.sh  = {ctl_q.sh[DW-2:0], mdio_i};
                ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                if (ctl_q.cnt == ADDR_LAST) begin
                    ctl_d.hit   = addr_hit;
                    ctl_d.raddr = addr_reg;
                    ctl_d.cnt   = '0;
                    ctl_d.st    = S_TA;
                end
            end
            S_TA: begin
                if (ctl_q.is_rd) begin
                    ctl_d.oe  = ctl_q.hit;
                    ctl_d.cnt = '0;
                    ctl_d.st  = S_RDATA;
                end else if (ctl_q.cnt == '0) begin
                    ctl_d.cnt = CNT_W'(1);
                end else begin
                    ctl_d.cnt = '0;
                    ctl_d.st  = S_WDATA;
                end
            end
            S_WDATA: begin
                ctl_d.sh  = {ctl_q.sh[DW-2:0], mdio_i};
                ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                if (ctl_q.cnt == DATA_LAST) begin
                    ctl_d.wdata = {ctl_q.sh[DW-2:0], mdio_i};
                    ctl_d.wr    = ctl_q.hit & reg_present;
                    ctl_d.cnt   = '0;
                    ctl_d.st    = S_HUNT;
                end
            end
            S_RDATA: begin
                ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                if (ctl_q.cnt == RD_END) begin
                    ctl_d.oe  = 1'b0;
                    ctl_d.cnt = '0;
                    ctl_d.st  = S_HUNT;
                end
            end
            default: ctl_d.st = S_HUNT;
        endcase
    end

    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: S_HUNT, cnt: '0, sh: '0, is_rd: 1'b0, hit: 1'b0,
                       raddr: '0, wr: 1'b0, wdata: '0, oe: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mdio_oe   = ctl_q.oe;
    assign mdio_o    = ctl_q.oe ? tx_bit : 1'b1;
    assign reg_addr  = ctl_q.raddr;
    assign reg_wr    = ctl_q.wr;
    assign reg_wdata = ctl_q.wdata;

endmodule

// File: rtl/mdio_slv_chk.sv
module mdio_slv_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mdio_oe,
    input logic          mdio_o,
    input logic          reg_wr,
    input logic          reg_present,
    input logic [AW-1:0] reg_addr
);

    // R1: outputs quiet while reset is held
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (!mdio_oe && !reg_wr));

    // R3: address stays put while data is being driven
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> $stable(reg_addr));

    // R4: first driven bit is the turnaround zero
    p_ta_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);

    // R5: no write strobe during a read
    p_no_wr_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> !reg_wr);

    // R6: the strobe is a single cycle
    p_wr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R9: no strobe to an absent register
    p_wr_present_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> reg_present);

endmodule

bind mdio_slave mdio_slv_chk #(
    .AW (mdio_slv_pkg::MDIO_AW)
) u_chk (
    .clk         (mdc),
    .rst_n       (rst_n),
    .mdio_oe     (mdio_oe),
    .mdio_o      (mdio_o),
    .reg_wr      (reg_wr),
    .reg_present (reg_present),
    .reg_addr    (reg_addr)
);

// File: tb/mdio_slave_bench.sv
module mdio_slave_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV         = 12;
    localparam logic [4:0] MY_PHY = 5'd1;

    // {is_read, phy, reg, data}
    localparam logic [26:0] VEC [NV] = '{
        {1'b0, 5'd1, 5'd2,  16'hA5C3},
        {1'b1, 5'd1, 5'd2,  16'h0000},
        {1'b0, 5'd0, 5'd3,  16'h1234},
        {1'b1, 5'd1, 5'd3,  16'h0000},
        {1'b0, 5'd2, 5'd2,  16'hFFFF},
        {1'b1, 5'd1, 5'd2,  16'h0000},
        {1'b1, 5'd2, 5'd2,  16'h0000},
        {1'b0, 5'd1, 5'd9,  16'hBEEF},
        {1'b1, 5'd1, 5'd9,  16'h0000},
        {1'b1, 5'd0, 5'd20, 16'h0000},
        {1'b0, 5'd1, 5'd20, 16'h0001},
        {1'b1, 5'd0, 5'd20, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        mst = 1'b1;
    logic        mst_en = 1'b0;
    logic        mdio_line;
    logic        mdio_o, mdio_oe;
    logic [4:0]  reg_addr;
    logic [15:0] reg_rdata;
    logic        reg_present;
    logic        reg_wr;
    logic [15:0] reg_wdata;

    logic [15:0] mem     [32];
    logic [15:0] exp_mem [32];
    int          wr_cnt = 0;
    int          oe_cnt = 0;
    int          checks = 0;
    int          errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mdio_line = mdio_oe ? mdio_o : (mst_en ? mst : 1'b1);

    function automatic logic pres(input logic [4:0] a);
        return (a < 5'd8) || (a == 5'd20);
    endfunction

    function automatic logic [15:0] init_val(input int i);
        return 16'h5A00 ^ (16'(i) * 16'h0101);
    endfunction

    assign reg_rdata   = mem[reg_addr];
    assign reg_present = pres(reg_addr);

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) mem[i] <= init_val(i);
        end else begin
            if (reg_wr) begin
                mem[reg_addr] <= reg_wdata;
                wr_cnt = wr_cnt + 1;
            end
            if (mdio_oe) oe_cnt = oe_cnt + 1;
        end
    end

    mdio_slave #(.PHY_ADDR(MY_PHY)) u_mdio_slave (
        .mdc         (clk),
        .rst_n       (rst_n),
        .mdio_i      (mdio_line),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe),
        .reg_addr    (reg_addr),
        .reg_rdata   (reg_rdata),
        .reg_present (reg_present),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic b);
        @(negedge clk);
        mst_en = 1'b1;
        mst    = b;
    endtask

    task automatic header(input int pre, input logic rd, input logic [4:0] phy, input logic [4:0] ra);
        for (int i = 0; i < pre; i++) send(1'b1);
        send(1'b0); send(1'b1);
        if (rd) begin send(1'b1); send(1'b0); end
        else    begin send(1'b0); send(1'b1); end
        for (int i = 4; i >= 0; i--) send(phy[i]);
        for (int i = 4; i >= 0; i--) send(ra[i]);
    endtask

    task automatic do_write(input int pre, input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd);
        logic drive, commit;
        int   w0;
        drive  = (phy == MY_PHY) || (phy == 5'd0);
        commit = drive && pres(ra);
        w0     = wr_cnt;
        header(pre, 1'b0, phy, ra);
        send(1'b1); send(1'b0);
        for (int i = 15; i >= 0; i--) begin
            send(wd[i]);
            if (i == 0) check(reg_wr == 1'b0, "R6 early strobe", 32'(reg_wr), 32'd0);
        end
        @(negedge clk);
        mst = 1'b1;
        if (commit) begin
            check(reg_wr == 1'b1 && reg_wdata == wd, "R6 strobe/data",
                  {15'd0, reg_wr, reg_wdata}, {16'd1, wd});
            exp_mem[ra] = wd;
        end
        @(negedge clk);
        if (!drive)
            check(wr_cnt == w0, "R8 write to other PHY", 32'(wr_cnt - w0), 32'd0);
        else if (!pres(ra))
            check(wr_cnt == w0, "R9 write to absent reg", 32'(wr_cnt - w0), 32'd0);
        else if (phy == 5'd0)
            check(wr_cnt == w0 + 1, "R7 broadcast write", 32'(wr_cnt - w0), 32'd1);
        else
            check(wr_cnt == w0 + 1, "R6 write count", 32'(wr_cnt - w0), 32'd1);
    endtask

    task automatic do_read(input int pre, input logic [4:0] phy, input logic [4:0] ra);
        logic        drive;
        logic [15:0] rv, ev;
        int          oe_bad;
        string       tag;
        drive  = (phy == MY_PHY) || (phy == 5'd0);
        ev     = (drive && pres(ra)) ? exp_mem[ra] : 16'hFFFF;
        oe_bad = 0;
        header(pre, 1'b1, phy, ra);
        @(negedge clk);
        mst_en = 1'b0;
        check(mdio_oe == 1'b0, "R4 first TA undriven", 32'(mdio_oe), 32'd0);
        @(negedge clk);
        check(mdio_oe == drive && (!drive || mdio_o == 1'b0), "R4 second TA",
              {mdio_oe, mdio_o}, {drive, 1'b0});
        for (int j = 15; j >= 0; j--) begin
            @(negedge clk);
            rv[j] = mdio_line;
            if (mdio_oe != drive) oe_bad++;
        end
        check(oe_bad == 0, "R5 drive over data bits", 32'(oe_bad), 32'd0);
        @(negedge clk);
        check(mdio_oe == 1'b0, "R5 release after last bit", 32'(mdio_oe), 32'd0);
        if (!drive)          tag = "R8 read other PHY";
        else if (!pres(ra))  tag = "R9 read absent reg";
        else if (phy == 0)   tag = "R7 broadcast read";
        else                 tag = "R5 read data";
        check(rv == ev, tag, 32'(rv), 32'(ev));
        mst_en = 1'b1;
        mst    = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [26:0] v;
        int w0, o0;
        for (int i = 0; i < 32; i++) exp_mem[i] = init_val(i);
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1
        check(mdio_oe == 1'b0 && reg_wr == 1'b0, "R1 reset outputs", {mdio_oe, reg_wr}, 32'd0);
        rst_n = 1'b1;
        mst_en = 1'b1;
        mst    = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            if (v[26]) do_read(1, v[25:21], v[20:16]);
            else       do_write(1, v[25:21], v[20:16], v[15:0]);
        end

        // R2: full 32-bit preamble also accepted; R3: address presented
        do_read(32, MY_PHY, 5'd4);
        check(reg_addr == 5'd4, "R3 reg_addr after frame", 32'(reg_addr), 32'd4);
        do_write(32, MY_PHY, 5'd5, 16'h8001);
        do_read(1, MY_PHY, 5'd5);
        check(exp_mem[5] == 16'h8001 && mem[5] == 16'h8001, "R2 long preamble write", 32'(mem[5]), 32'h8001);

        // R10: bad start pattern, then zeros
        w0 = wr_cnt; o0 = oe_cnt;
        send(1'b1); send(1'b0); send(1'b0);
        for (int i = 0; i < 14; i++) send(1'b0);
        @(negedge clk);
        check(wr_cnt == w0 && oe_cnt == o0, "R10 bad start", 32'(oe_cnt - o0), 32'd0);
        // R10: opcode 11
        send(1'b1); send(1'b0); send(1'b1); send(1'b1); send(1'b1);
        for (int i = 0; i < 30; i++) send(1'b0);
        @(negedge clk);
        check(wr_cnt == w0 && oe_cnt == o0, "R10 opcode 11", 32'(oe_cnt - o0), 32'd0);
        // R10: opcode 00
        send(1'b1); send(1'b0); send(1'b1); send(1'b0); send(1'b0);
        for (int i = 0; i < 30; i++) send(1'b0);
        @(negedge clk);
        check(wr_cnt == w0 && oe_cnt == o0, "R10 opcode 00", 32'(oe_cnt - o0), 32'd0);
        // R10: next valid frame served
        do_read(1, MY_PHY, 5'd3);
        check(reg_addr == 5'd3, "R10 recovery address", 32'(reg_addr), 32'd3);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule